// File: doc/BRIEF.md
# Parallel Flash Bus-Operation Decoder

This block serves the host side of an asynchronous parallel NOR-style memory. It samples the active-low chip enable, output enable, write enable and device reset pins on a system clock and decodes them into one bus operation: read, write, standby, output disable, reset, or a conflict when output enable and write enable are both low. A byte-select pin picks between a 16-bit word bus and an 8-bit byte bus. In byte mode the top data pin becomes the lowest address bit, which selects the byte.

Reads come from a small internal array whose contents are computed, not stored, and whose output is registered. The block starts in read-array mode, so reads need no command. After an accepted write it returns a fixed status word. A reset command value, or a low level on the device reset pin, puts it back in read-array mode. Each write produces one address/data strobe toward a downstream command register. When write protect is low, writes to the two outermost boot sectors are blocked and flagged.

Top module: `flash_bus_decoder`

## Requirements
- R1: `op` shows the decode of the inputs sampled at the previous clock edge, with reset=0, standby=1, output-disable=2, read=3, write=4 and conflict=5. Priority order: device reset pin low, then chip enable high, then the output-enable/write-enable pair (high/high=2, low/high=3, high/low=4, low/low=5).
- R2: A read in word mode (`byte_n`=1) sets `dq_oe`=16'hFFFF. In read-array mode `dq_out` is the array word at index i = addr[3:0], defined as {i^8'h3C, i^8'hA5} with i taken as 8 bits.
- R3: A read in byte mode (`byte_n`=0) sets `dq_oe`=16'h00FF. `dq_in[15]` acts as the extra low address bit: 0 puts the low byte of the word on `dq_out[7:0]`, 1 puts the high byte there. `dq_out[15:8]` is 0.
- R4: For every operation other than read, `dq_oe` is 0.
- R5: A write gives exactly one one-cycle `cmd_valid` pulse, in the cycle after chip enable or write enable rises. `cmd_addr`={addr, A-1} and `cmd_data` are taken from the inputs at that edge. A-1 is `dq_in[15]` in byte mode and 0 in word mode. In byte mode `cmd_data` is {8'h00, dq_in[7:0]}.
- R6: While chip enable is high, write-enable activity produces no strobe.
- R7: With `wp_n`=0, a write to sector addr[19:15]=0 or =31 gives a `cmd_blocked` pulse instead of `cmd_valid` and leaves the read mode unchanged. With `wp_n`=1 the same write is accepted.
- R8: After system reset the block is in read-array mode. An accepted write whose data low byte is not 8'hF0 switches it to status mode, where reads return 16'h0080.
- R9: An accepted write with data low byte 8'hF0 restores read-array mode. So does a low device reset pin, which also cancels any write in progress without a strobe.
- R10: While `rst_n` is low and after its release with chip enable high, `op`=1, `dq_oe`=0, `cmd_valid`=0 and `cmd_blocked`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| rst_pin_n | input | 1 | Device reset pin, active low |
| byte_n | input | 1 | 1 = word bus, 0 = byte bus |
| wp_n | input | 1 | Boot-sector write protect, active low |
| addr | input | 20 | Word address |
| dq_in | input | 16 | Data pins as seen from outside (bit 15 = A-1 in byte mode) |
| dq_out | output | 16 | Data driven onto the pins |
| dq_oe | output | 16 | Per-pin output enable |
| op | output | 3 | Decoded bus operation |
| cmd_valid | output | 1 | One-cycle strobe to the command register |
| cmd_blocked | output | 1 | One-cycle flag for a blocked protected write |
| cmd_addr | output | 21 | Byte-resolution address of the strobed write |
| cmd_data | output | 16 | Data of the strobed write |

## Verification
A wrong read-mode flag shows on the first read after the write that caused it: the pins carry 16'h0080 instead of array data, or the reverse. A stale write-tracking flag shows one cycle after chip enable or write enable rises, as a strobe that is missing or extra. A byte-steering error shows at once as the wrong `dq_oe` pattern or the wrong byte. Every check is therefore made in the cycle directly after the stimulus edge.

// File: rtl/fbd_pkg.sv
// Package: shared operation type and the computed array contents.
// Assumes a 16-bit data bus and array indices of at most 8 bits.
package fbd_pkg;

    localparam int DQ_W = 16;

    typedef enum logic [2:0] {
        OP_RESET    = 3'd0,
        OP_STANDBY  = 3'd1,
        OP_OUTDIS   = 3'd2,
        OP_READ     = 3'd3,
        OP_WRITE    = 3'd4,
        OP_CONFLICT = 3'd5
    } bus_op_e;

    // Array word for an index: computed so no table is stored.
    function automatic logic [DQ_W-1:0] rom_word(input logic [7:0] idx);
        return {idx ^ 8'h3C, idx ^ 8'hA5};
    endfunction

endpackage

// File: rtl/fbd_op_decode.sv
// Operation decoder: turns the control pins into one bus operation.
// Gives a combinational decode for this edge and a registered copy.
// Assumes the pins are already synchronous to clk.
module fbd_op_decode
    import fbd_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    input  logic    rst_pin_n,
    output bus_op_e op_now,
    output bus_op_e op_q
);

    // Priority decode: device reset, then standby, then the oe/we pair.
    always_comb begin
        if (!rst_pin_n)         op_now = OP_RESET;
        else if (ce_n)          op_now = OP_STANDBY;
        else if (oe_n && we_n)  op_now = OP_OUTDIS;
        else if (!oe_n && we_n) op_now = OP_READ;
        else if (oe_n && !we_n) op_now = OP_WRITE;
        else                    op_now = OP_CONFLICT;
    end

    // Register the decode for the op output.
    always_ff @(posedge clk) begin
        if (!rst_n) op_q <= OP_STANDBY;
        else        op_q <= op_now;
    end

endmodule

// File: rtl/fbd_read_path.sv
// Read path: registered array/status read with word or byte steering.
// The pins are enabled only for a read. In byte mode only the low
// eight pins are driven, and the selected byte comes from the extra
// low address bit. Assumes ROM_AW <= 8.
module fbd_read_path
    import fbd_pkg::*;
#(
    parameter int              ADDR_W      = 20,
    parameter int              ROM_AW      = 4,
    parameter logic [DQ_W-1:0] STATUS_WORD = 16'h0080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_e           op_now,
    input  logic              byte_n,
    input  logic              a_m1,
    input  logic [ADDR_W-1:0] addr,
    input  logic              read_mode,
    output logic [DQ_W-1:0]   dq_out,
    output logic [DQ_W-1:0]   dq_oe
);

    localparam int HALF = DQ_W / 2;

    logic [7:0]      rom_idx;
    logic [DQ_W-1:0] word_sel;
    logic [HALF-1:0] byte_sel;

    // Select the array word or the status word, then the byte lane.
    always_comb begin
        rom_idx  = 8'(addr[ROM_AW-1:0]);
        word_sel = read_mode ? rom_word(rom_idx) : STATUS_WORD;
        byte_sel = a_m1 ? word_sel[DQ_W-1:HALF] : word_sel[HALF-1:0];
    end

    // Register pin data and enables; tri-state outside a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
            dq_oe  <= '0;
        end else if (op_now == OP_READ) begin
            if (byte_n) begin
                dq_out <= word_sel;
                dq_oe  <= '1;
            end else begin
                dq_out <= {{HALF{1'b0}}, byte_sel};
                dq_oe  <= {{HALF{1'b0}}, {HALF{1'b1}}};
            end
        end else begin
            dq_out <= '0;
            dq_oe  <= '0;
        end
    end

endmodule

// File: rtl/fbd_write_capture.sv
// Write capture: tracks an active write cycle and issues one strobe
// when chip enable or write enable rises. Address and data are taken
// at that edge. Also applies boot-sector protection and keeps the
// read-array / status mode flag. Assumes SECT_W < ADDR_W.
module fbd_write_capture
    import fbd_pkg::*;
#(
    parameter int         ADDR_W    = 20,
    parameter int         SECT_W    = 5,
    parameter logic [7:0] RESET_CMD = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_e           op_now,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              rst_pin_n,
    input  logic              byte_n,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output logic              cmd_valid,
    output logic              cmd_blocked,
    output logic [ADDR_W:0]   cmd_addr,
    output logic [DQ_W-1:0]   cmd_data,
    output logic              read_mode
);

    localparam int HALF = DQ_W / 2;

    logic              wr_q;
    logic              wr_end;
    logic [SECT_W-1:0] sector;
    logic              boot_hit;
    logic              protect;
    logic              a_m1;
    logic [DQ_W-1:0]   wdata;

    // Work out the end of a write, the protection outcome and the captured fields.
    always_comb begin
        wr_end   = wr_q && rst_pin_n && (ce_n || we_n);
        sector   = addr[ADDR_W-1 -: SECT_W];
        boot_hit = (sector == '0) || (sector == '1);
        protect  = !wp_n && boot_hit;
        a_m1     = byte_n ? 1'b0 : dq_in[DQ_W-1];
        wdata    = byte_n ? dq_in : {{HALF{1'b0}}, dq_in[HALF-1:0]};
    end

    // Track the write, send strobes and update the mode flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q        <= 1'b0;
            cmd_valid   <= 1'b0;
            cmd_blocked <= 1'b0;
            cmd_addr    <= '0;
            cmd_data    <= '0;
            read_mode   <= 1'b1;
        end else begin
            wr_q        <= (op_now == OP_WRITE);
            cmd_valid   <= 1'b0;
            cmd_blocked <= 1'b0;
            if (!rst_pin_n) begin
                read_mode <= 1'b1;
            end else if (wr_end) begin
                cmd_addr <= {addr, a_m1};
                cmd_data <= wdata;
                if (protect) begin
                    cmd_blocked <= 1'b1;
                end else begin
                    cmd_valid <= 1'b1;
                    read_mode <= (wdata[HALF-1:0] == RESET_CMD);
                end
            end
        end
    end

endmodule

// File: rtl/flash_bus_decoder.sv
// Top: parallel flash bus-operation decoder. Connects the decoder,
// the read path and the write capture. The byte-mode extra address
// bit is taken from the top data pin. All outputs are registered,
// one clock after the pins are sampled.
module flash_bus_decoder
    import fbd_pkg::*;
#(
    parameter int              ADDR_W      = 20,
    parameter int              ROM_AW      = 4,
    parameter int              SECT_W      = 5,
    parameter logic [15:0]     STATUS_WORD = 16'h0080,
    parameter logic [7:0]      RESET_CMD   = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              rst_pin_n,
    input  logic              byte_n,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe,
    output logic [2:0]        op,
    output logic              cmd_valid,
    output logic              cmd_blocked,
    output logic [ADDR_W:0]   cmd_addr,
    output logic [15:0]       cmd_data
);

    bus_op_e op_now;
    bus_op_e op_q;
    logic    read_mode;
    logic    a_m1;

    // Byte-mode extra address bit comes from the top data pin.
    always_comb begin
        a_m1 = dq_in[DQ_W-1];
        op   = op_q;
    end

    fbd_op_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .rst_pin_n (rst_pin_n),
        .op_now    (op_now),
        .op_q      (op_q)
    );

    fbd_read_path #(
        .ADDR_W      (ADDR_W),
        .ROM_AW      (ROM_AW),
        .STATUS_WORD (STATUS_WORD)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_now    (op_now),
        .byte_n    (byte_n),
        .a_m1      (a_m1),
        .addr      (addr),
        .read_mode (read_mode),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    fbd_write_capture #(
        .ADDR_W    (ADDR_W),
        .SECT_W    (SECT_W),
        .RESET_CMD (RESET_CMD)
    ) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_now      (op_now),
        .ce_n        (ce_n),
        .we_n        (we_n),
        .rst_pin_n   (rst_pin_n),
        .byte_n      (byte_n),
        .wp_n        (wp_n),
        .addr        (addr),
        .dq_in       (dq_in),
        .cmd_valid   (cmd_valid),
        .cmd_blocked (cmd_blocked),
        .cmd_addr    (cmd_addr),
        .cmd_data    (cmd_data),
        .read_mode   (read_mode)
    );

endmodule

// File: rtl/flash_bus_decoder_chk.sv
// Checker: port-level properties of the bus decoder, bound to the top.
module flash_bus_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        oe_n,
    input logic        we_n,
    input logic        rst_pin_n,
    input logic        byte_n,
    input logic [15:0] dq_oe,
    input logic [2:0]  op,
    input logic        cmd_valid,
    input logic        cmd_blocked
);

    a_r4_hiz_unless_read: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 3'd3) |-> (dq_oe == 16'h0000));

    a_r2_word_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3 && $past(byte_n)) |-> (dq_oe == 16'hFFFF));

    a_r3_byte_enables: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3 && !$past(byte_n)) |-> (dq_oe == 16'h00FF));

    a_r1_write_decode: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd4) |-> $past(!ce_n && oe_n && !we_n && rst_pin_n));

    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r6_strobe_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(!ce_n && oe_n && !we_n && rst_pin_n, 2));

    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_blocked));

    a_r9_pin_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_pin_n) |-> (op == 3'd0 && !cmd_valid && !cmd_blocked));

endmodule

bind flash_bus_decoder flash_bus_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .rst_pin_n   (rst_pin_n),
    .byte_n      (byte_n),
    .dq_oe       (dq_oe),
    .op          (op),
    .cmd_valid   (cmd_valid),
    .cmd_blocked (cmd_blocked)
);

// File: tb/flash_bus_decoder_bench.sv
module flash_bus_decoder_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic        rst_pin_n = 1'b1, byte_n = 1'b1, wp_n = 1'b1;
    logic [19:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out, dq_oe, cmd_data;
    logic [2:0]  op;
    logic        cmd_valid, cmd_blocked;
    logic [20:0] cmd_addr;

    int checks = 0;
    int failures = 0;

    flash_bus_decoder u_flash_bus_decoder (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rst_pin_n(rst_pin_n), .byte_n(byte_n), .wp_n(wp_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .op(op),
        .cmd_valid(cmd_valid), .cmd_blocked(cmd_blocked),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] exp_word(input logic [7:0] i);
        return {i ^ 8'h3C, i ^ 8'hA5};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge and sample just after it.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pins(input logic c, input logic o, input logic w);
        ce_n = c; oe_n = o; we_n = w;
    endtask

    // Full write cycle; ends by raising we_n (end_ce=0) or ce_n (end_ce=1).
    task automatic do_write(input logic [19:0] a, input logic [15:0] d, input logic end_ce);
        addr = a; dq_in = d;
        pins(1'b0, 1'b1, 1'b0);
        step();
        check("R1 write op", 32'(op), 32'd4);
        if (end_ce) pins(1'b1, 1'b1, 1'b0);
        else        pins(1'b0, 1'b1, 1'b1);
        step();
    endtask

    task automatic t_reset();
        check("R10 op after reset", 32'(op), 32'd1);
        check("R10 dq_oe after reset", 32'(dq_oe), 32'd0);
        check("R10 strobes after reset", {cmd_valid, cmd_blocked}, 32'd0);
    endtask

    task automatic t_word_read();
        byte_n = 1'b1;
        for (int i = 0; i < 16; i += 5) begin
            addr = 20'(i) | 20'h12340;
            pins(1'b0, 1'b0, 1'b1);
            step();
            check("R1 read op", 32'(op), 32'd3);
            check("R2 word oe", 32'(dq_oe), 32'hFFFF);
            check("R2 word data", 32'(dq_out), 32'(exp_word(8'(i))));
        end
        pins(1'b1, 1'b1, 1'b1);
        step();
    endtask

    task automatic t_byte_read();
        logic [15:0] w;
        byte_n = 1'b0;
        addr = 20'h00007;
        w = exp_word(8'd7);
        pins(1'b0, 1'b0, 1'b1);
        dq_in = 16'h0000;
        step();
        check("R3 byte oe", 32'(dq_oe), 32'h00FF);
        check("R3 low byte", 32'(dq_out), 32'({8'h00, w[7:0]}));
        dq_in = 16'h8000;
        step();
        check("R3 high byte", 32'(dq_out), 32'({8'h00, w[15:8]}));
        pins(1'b1, 1'b1, 1'b1);
        byte_n = 1'b1; dq_in = '0;
        step();
    endtask

    task automatic t_hiz();
        pins(1'b0, 1'b1, 1'b1);
        step();
        check("R1 outdis op", 32'(op), 32'd2);
        check("R4 outdis oe", 32'(dq_oe), 32'd0);
        pins(1'b0, 1'b0, 1'b0);
        step();
        check("R1 conflict op", 32'(op), 32'd5);
        check("R4 conflict oe", 32'(dq_oe), 32'd0);
        pins(1'b1, 1'b0, 1'b1);
        step();
        check("R1 standby op", 32'(op), 32'd1);
        check("R4 standby oe", 32'(dq_oe), 32'd0);
        check("R5 no strobe after conflict", 32'(cmd_valid), 32'd0);
        rst_pin_n = 1'b0;
        pins(1'b0, 1'b0, 1'b1);
        step();
        check("R1 reset op", 32'(op), 32'd0);
        check("R4 reset oe", 32'(dq_oe), 32'd0);
        rst_pin_n = 1'b1;
        pins(1'b1, 1'b1, 1'b1);
        step();
    endtask

    task automatic t_standby_write();
        addr = 20'h40005; dq_in = 16'h1111;
        pins(1'b1, 1'b1, 1'b0);
        step();
        check("R6 standby no strobe", 32'(cmd_valid), 32'd0);
        pins(1'b1, 1'b1, 1'b1);
        step();
        check("R6 standby we rise no strobe", 32'(cmd_valid), 32'd0);
        pins(1'b0, 1'b0, 1'b1);
        addr = 20'h00003;
        step();
        check("R6 still read-array", 32'(dq_out), 32'(exp_word(8'd3)));
        pins(1'b1, 1'b1, 1'b1);
        step();
    endtask

    task automatic t_write_word_status();
        byte_n = 1'b1;
        do_write(20'h40005, 16'h1234, 1'b0);
        check("R5 strobe", 32'(cmd_valid), 32'd1);
        check("R5 cmd_addr", 32'(cmd_addr), 32'h8000A);
        check("R5 cmd_data", 32'(cmd_data), 32'h1234);
        pins(1'b1, 1'b1, 1'b1);
        step();
        check("R5 strobe one cycle", 32'(cmd_valid), 32'd0);
        addr = 20'h00002;
        pins(1'b0, 1'b0, 1'b1);
        step();
        check("R8 status read", 32'(dq_out), 32'h0080);
        pins(1'b1, 1'b1, 1'b1);
        step();
        do_write(20'h40000, 16'h00F0, 1'b1);
        check("R9 reset cmd strobe via ce", 32'(cmd_valid), 32'd1);
        addr = 20'h00002;
        pins(1'b0, 1'b0, 1'b1);
        step();
        check("R9 array after reset cmd", 32'(dq_out), 32'(exp_word(8'd2)));
        pins(1'b1, 1'b1, 1'b1);
        step();
    endtask

    task automatic t_byte_write_pin_reset();
        byte_n = 1'b0;
        do_write(20'h40006, 16'h80AB, 1'b0);
        check("R5 byte cmd_addr", 32'(cmd_addr), 32'h8000D);
        check("R5 byte cmd_data", 32'(cmd_data), 32'h00AB);
        byte_n = 1'b1;
        pins(1'b1, 1'b1, 1'b1);
        rst_pin_n = 1'b0;
        step();
        rst_pin_n = 1'b1;
        addr = 20'h00009; dq_in = '0;
        pins(1'b0, 1'b0, 1'b1);
        step();
        check("R9 array after reset pin", 32'(dq_out), 32'(exp_word(8'd9)));
        pins(1'b1, 1'b1, 1'b1);
        step();
    endtask

    task automatic t_protect();
        byte_n = 1'b1;
        wp_n = 1'b0;
        do_write(20'h00003, 16'h0055, 1'b0);
        check("R7 low sector blocked", {cmd_valid, cmd_blocked}, 32'd1);
        do_write(20'hFFFF0, 16'h0055, 1'b0);
        check("R7 top sector blocked", {cmd_valid, cmd_blocked}, 32'd1);
        addr = 20'h00004;
        pins(1'b0, 1'b0, 1'b1);
        step();
        check("R7 mode unchanged", 32'(dq_out), 32'(exp_word(8'd4)));
        wp_n = 1'b1;
        do_write(20'h00003, 16'h0055, 1'b0);
        check("R7 accepted with wp high", {cmd_valid, cmd_blocked}, 32'd2);
        do_write(20'h00000, 16'h00F0, 1'b0);
        pins(1'b1, 1'b1, 1'b1);
        step();
    endtask

    task automatic t_abort();
        addr = 20'h40001; dq_in = 16'h0077;
        pins(1'b0, 1'b1, 1'b0);
        step();
        rst_pin_n = 1'b0;
        step();
        check("R9 abort no strobe", 32'(cmd_valid), 32'd0);
        rst_pin_n = 1'b1;
        pins(1'b1, 1'b1, 1'b1);
        step();
        check("R9 abort no strobe after release", 32'(cmd_valid), 32'd0);
        addr = 20'h00001;
        pins(1'b0, 1'b0, 1'b1);
        step();
        check("R9 abort keeps array mode", 32'(dq_out), 32'(exp_word(8'd1)));
        pins(1'b1, 1'b1, 1'b1);
        step();
    endtask

    initial begin
        #(CLK_P * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        step(); step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_word_read();
        t_byte_read();
        t_hiz();
        t_standby_write();
        t_write_word_status();
        t_byte_write_pin_reset();
        t_protect();
        t_abort();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule